// File: doc/BRIEF.md
# Packed Single-Precision Vector Adder with Framed Stream Join

This processing element merges two framed 64-bit streams into one. Every frame opens with a length word followed by that many payload words. The block takes the length word from both inputs at once. It keeps the copy from input A as the frame length and forwards it to the output ahead of any result. After that it pulls one payload word from each input per transfer, in lockstep, until the frame's count is used up.

Each payload word packs two IEEE-754 single-precision values. The block adds the matching lanes of the two inputs independently and packs the two sums into the output word in the same positions. The arithmetic flushes denormals to zero and rounds to nearest, with ties to even. It gives signed infinity on overflow and one canonical quiet NaN for invalid cases.

All three ports use valid/ready flow control. A two-stage pipeline accepts one pair per clock when nothing stalls it.

Top module: `pfadd_join`

## Requirements
- R1: The first word of a frame on the output is the length word taken from input A. It is sent before any result word of that frame. The length word on input B is consumed but has no effect on the output.
- R2: `src_a_ready` and `src_b_ready` are always equal. They are high only when both inputs are valid, and they are always high when both inputs are valid and `sum_ready` is high.
- R3: Lane 0 occupies bits 31:0 and lane 1 occupies bits 63:32 of every payload and result word. Each result lane is the sum of the two input lanes at the same position.
- R4: Sums round to nearest, with ties going to the even significand.
- R5: An operand whose exponent field is 0 is treated as a zero carrying that operand's sign.
- R6: A nonzero sum whose magnitude is below 2^-126 becomes a zero carrying the sum's sign. Exact cancellation of nonzero operands gives +0, and -0 plus -0 gives -0. No output lane ever has exponent field 0 with a nonzero fraction.
- R7: A sum whose rounded exponent exceeds the largest finite value becomes an infinity carrying the sum's sign.
- R8: A NaN operand, or infinities of opposite sign, give 0x7FC00000. An infinity plus any finite value gives that infinity.
- R9: A frame of length 0 produces only its length word on the output. The next transfer is then taken as a new header.
- R10: A word accepted at one rising edge appears on the output after the second following edge. With the output ready and both inputs valid, a frame of N payload words is accepted in N+1 consecutive cycles.
- R11: While `sum_valid` is high and `sum_ready` is low, `sum_valid` and `sum_data` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_a_data | input | 64 | Input A word (length or packed operands) |
| src_a_valid | input | 1 | Input A word present |
| src_a_ready | output | 1 | Input A word taken |
| src_b_data | input | 64 | Input B word (length or packed operands) |
| src_b_valid | input | 1 | Input B word present |
| src_b_ready | output | 1 | Input B word taken |
| sum_data | output | 64 | Output word (length or packed sums) |
| sum_valid | output | 1 | Output word present |
| sum_ready | input | 1 | Downstream takes output word |

## Verification
Every word the block accepts is due on the output exactly two clock edges later, as long as nothing stalls. While backpressure is active, the output word must stay frozen until it is taken. The bench stamps each accepted pair with its cycle number in a queue, and compares each output transfer against the front of an expected-value queue. In the stall-free phase it also requires the output to arrive exactly two cycles after that pair's stamp. The ready rule is checked on every cycle, directly against the input valids and `sum_ready`. Expected sums come from an exact wide-integer model with its own rounding, which shares no structure with the pipeline.

// File: rtl/pfadd_pkg.sv
package pfadd_pkg;

  localparam int FP_W  = 32;
  localparam int EXP_W = 8;
  localparam int MAN_W = 23;
  localparam int SIG_W = MAN_W + 1;
  localparam int EXT_W = SIG_W + 3;
  localparam int LZ_W  = $clog2(EXT_W + 1);
  localparam logic [FP_W-1:0] QNAN_VAL = 32'h7FC0_0000;

  typedef struct packed {
    logic             sign;
    logic [EXP_W-1:0] exp;
    logic [MAN_W-1:0] man;
  } fp32_t;

  typedef struct packed {
    logic             spec;
    logic [FP_W-1:0]  spec_val;
    logic             sign;
    logic             eff_sub;
    logic [EXP_W-1:0] exp;
    logic [EXT_W:0]   mag;
  } lane_mid_t;

  function automatic logic fp_is_nan(fp32_t x);
    return (&x.exp) && (|x.man);
  endfunction

  function automatic logic fp_is_inf(fp32_t x);
    return (&x.exp) && !(|x.man);
  endfunction

  // significand with hidden bit; exponent 0 flushes to zero
  function automatic logic [SIG_W-1:0] fp_sig(fp32_t x);
    return (x.exp == '0) ? '0 : {1'b1, x.man};
  endfunction

  // right shift keeping a sticky bit in the LSB
  function automatic logic [EXT_W-1:0] align_sig(logic [EXT_W-1:0] v,
                                                 logic [EXP_W-1:0] d);
    logic [EXT_W-1:0] sh;
    logic [EXT_W-1:0] mask;
    logic             stk;
    if (d >= EXP_W'(EXT_W)) begin
      sh  = '0;
      stk = |v;
    end else begin
      sh   = v >> d;
      mask = ({{(EXT_W-1){1'b0}}, 1'b1} << d) - 1'b1;
      stk  = |(v & mask);
    end
    return {sh[EXT_W-1:1], sh[0] | stk};
  endfunction

  function automatic logic [LZ_W-1:0] lead_zeros(logic [EXT_W-1:0] v);
    logic [LZ_W-1:0] n;
    logic            found;
    n     = LZ_W'(EXT_W);
    found = 1'b0;
    for (int i = 0; i < EXT_W; i++) begin
      if (!found && v[EXT_W-1-i]) begin
        n     = LZ_W'(i);
        found = 1'b1;
      end
    end
    return n;
  endfunction

endpackage

// File: rtl/pfadd_frame_ctrl.sv
module pfadd_frame_ctrl #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [CNT_W-1:0] len_in,
  output logic             expect_hdr
);

  logic             in_body;
  logic [CNT_W-1:0] left;
  logic             hdr_take;
  logic             len_zero;
  logic             last_elem;

  assign hdr_take  = take && !in_body;
  assign len_zero  = (len_in == '0);
  assign last_elem = (left == {{(CNT_W-1){1'b0}}, 1'b1});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_body <= 1'b0;
      left    <= '0;
    end else if (take) begin
      if (!in_body) begin
        if (!len_zero) begin
          in_body <= 1'b1;
          left    <= len_in;
        end
      end else begin
        if (last_elem) in_body <= 1'b0;
        left <= left - 1'b1;
      end
    end
  end

  assign expect_hdr = !in_body;

  AST_ZERO_LEN_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_take && len_zero |=> !in_body); // R9

  AST_BODY_AFTER_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_take && !len_zero |=> in_body && (left == $past(len_in))); // R1

  AST_BODY_COUNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    in_body |-> (left != '0)); // R1

endmodule

// File: rtl/pfadd_lane.sv
module pfadd_lane
  import pfadd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap1,
  input  logic            cap2,
  input  logic [FP_W-1:0] op_a,
  input  logic [FP_W-1:0] op_b,
  output logic [FP_W-1:0] res
);

  // ---------------- stage 1: classify, align, add ----------------
  fp32_t            fa, fb, big, sml;
  logic             a_big;
  logic [EXP_W-1:0] ediff;
  logic [EXT_W-1:0] big_ext, sml_ext;
  logic             eff_sub;
  logic             spec_hit;
  logic [FP_W-1:0]  spec_val;
  lane_mid_t        mid_n, mid_q;

  assign fa = op_a;
  assign fb = op_b;
  assign a_big   = {fa.exp, fa.man} >= {fb.exp, fb.man};
  assign big     = a_big ? fa : fb;
  assign sml     = a_big ? fb : fa;
  assign ediff   = big.exp - sml.exp;
  assign big_ext = {fp_sig(big), 3'b000};
  assign sml_ext = align_sig({fp_sig(sml), 3'b000}, ediff);
  assign eff_sub = fa.sign ^ fb.sign;

  always_comb begin
    spec_hit = 1'b1;
    spec_val = QNAN_VAL;
    if (fp_is_nan(fa) || fp_is_nan(fb)) begin
      spec_val = QNAN_VAL;
    end else if (fp_is_inf(fa) && fp_is_inf(fb) && eff_sub) begin
      spec_val = QNAN_VAL;
    end else if (fp_is_inf(fa)) begin
      spec_val = {fa.sign, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
    end else if (fp_is_inf(fb)) begin
      spec_val = {fb.sign, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
    end else begin
      spec_hit = 1'b0;
    end
  end

  always_comb begin
    mid_n.spec     = spec_hit;
    mid_n.spec_val = spec_val;
    mid_n.sign     = big.sign;
    mid_n.eff_sub  = eff_sub;
    mid_n.exp      = big.exp;
    mid_n.mag      = eff_sub ? ({1'b0, big_ext} - {1'b0, sml_ext})
                             : ({1'b0, big_ext} + {1'b0, sml_ext});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mid_q <= '0;
    else if (cap1) mid_q <= mid_n;
  end

  // ---------------- stage 2: normalise, round, pack ----------------
  logic             carry_out;
  logic [LZ_W-1:0]  lz;
  logic [EXT_W-1:0] norm;
  logic [EXP_W:0]   exp_n;
  logic             mag_zero;
  logic             tiny;
  logic [SIG_W-1:0] mant;
  logic             g_bit, r_bit, s_bit;
  logic             round_up;
  logic [SIG_W:0]   rsum;
  logic [EXP_W:0]   exp_r;
  logic [MAN_W-1:0] frac;
  logic             ovf;
  logic [FP_W-1:0]  res_n, res_q;

  assign carry_out = mid_q.mag[EXT_W];
  assign mag_zero  = (mid_q.mag == '0);
  assign lz        = lead_zeros(mid_q.mag[EXT_W-1:0]);

  always_comb begin
    if (carry_out) begin
      norm  = {mid_q.mag[EXT_W:2], mid_q.mag[1] | mid_q.mag[0]};
      exp_n = {1'b0, mid_q.exp} + 1'b1;
    end else begin
      norm  = mid_q.mag[EXT_W-1:0] << lz;
      exp_n = {1'b0, mid_q.exp} - {{(EXP_W+1-LZ_W){1'b0}}, lz};
    end
  end

  assign tiny     = !carry_out && ({{(EXP_W-LZ_W){1'b0}}, lz} >= mid_q.exp);
  assign mant     = norm[EXT_W-1:3];
  assign g_bit    = norm[2];
  assign r_bit    = norm[1];
  assign s_bit    = norm[0];
  assign round_up = g_bit && (r_bit || s_bit || mant[0]);
  assign rsum     = {1'b0, mant} + {{SIG_W{1'b0}}, round_up};
  assign exp_r    = rsum[SIG_W] ? exp_n + 1'b1 : exp_n;
  assign frac     = rsum[SIG_W] ? rsum[SIG_W-1:1] : rsum[MAN_W-1:0];
  assign ovf      = exp_r >= {1'b0, {EXP_W{1'b1}}};

  always_comb begin
    if (mid_q.spec) begin
      res_n = mid_q.spec_val;
    end else if (mag_zero) begin
      res_n = {mid_q.sign && !mid_q.eff_sub, {(FP_W-1){1'b0}}};
    end else if (tiny) begin
      res_n = {mid_q.sign, {(FP_W-1){1'b0}}};
    end else if (ovf) begin
      res_n = {mid_q.sign, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
    end else begin
      res_n = {mid_q.sign, exp_r[EXP_W-1:0], frac};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) res_q <= '0;
    else if (cap2) res_q <= res_n;
  end

  assign res = res_q;

  AST_QNAN_CANON: assert property (@(posedge clk) disable iff (!rst_n)
    (&res_q[30:23]) && (|res_q[22:0]) |-> res_q == QNAN_VAL); // R8

  AST_NO_SUBNORM: assert property (@(posedge clk) disable iff (!rst_n)
    (res_q[30:23] == '0) |-> (res_q[22:0] == '0)); // R6

  AST_OVF_TO_INF: assert property (@(posedge clk) disable iff (!rst_n)
    cap2 && !mid_q.spec && !mag_zero && !tiny && ovf
      |=> res_q[30:0] == {{EXP_W{1'b1}}, {MAN_W{1'b0}}}); // R7

endmodule

// File: rtl/pfadd_join.sv
module pfadd_join
  import pfadd_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] src_a_data,
  input  logic              src_a_valid,
  output logic              src_a_ready,
  input  logic [DATA_W-1:0] src_b_data,
  input  logic              src_b_valid,
  output logic              src_b_ready,
  output logic [DATA_W-1:0] sum_data,
  output logic              sum_valid,
  input  logic              sum_ready
);

  localparam int LANES = DATA_W / FP_W;

  logic              adv1, adv2, pair_fire;
  logic              s1_v, s2_v;
  logic              s1_hdr, s2_hdr;
  logic [DATA_W-1:0] s1_len, s2_len;
  logic              expect_hdr;
  logic [DATA_W-1:0] lane_res;

  assign adv2      = !s2_v || sum_ready;
  assign adv1      = !s1_v || adv2;
  assign pair_fire = src_a_valid && src_b_valid && adv1;

  assign src_a_ready = pair_fire;
  assign src_b_ready = pair_fire;

  pfadd_frame_ctrl #(.CNT_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (pair_fire),
    .len_in     (src_a_data),
    .expect_hdr (expect_hdr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v   <= 1'b0;
      s1_hdr <= 1'b0;
      s1_len <= '0;
      s2_v   <= 1'b0;
      s2_hdr <= 1'b0;
      s2_len <= '0;
    end else begin
      if (adv1) begin
        s1_v <= pair_fire;
        if (pair_fire) begin
          s1_hdr <= expect_hdr;
          s1_len <= src_a_data;
        end
      end
      if (adv2) begin
        s2_v   <= s1_v;
        s2_hdr <= s1_hdr;
        s2_len <= s1_len;
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pfadd_lane u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .cap1  (pair_fire),
      .cap2  (adv2),
      .op_a  (src_a_data[g*FP_W +: FP_W]),
      .op_b  (src_b_data[g*FP_W +: FP_W]),
      .res   (lane_res[g*FP_W +: FP_W])
    );
  end

  assign sum_valid = s2_v;
  assign sum_data  = s2_hdr ? s2_len : lane_res;

  AST_READY_JOINT: assert property (@(posedge clk) disable iff (!rst_n)
    src_a_ready |-> src_a_valid && src_b_valid); // R2

  AST_READY_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    src_a_ready == src_b_ready); // R2

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    sum_valid && !sum_ready |=> sum_valid && $stable(sum_data)); // R11

  AST_ACCEPT_REACHES_S1: assert property (@(posedge clk) disable iff (!rst_n)
    pair_fire |=> s1_v); // R10

endmodule

// File: tb/pfadd_join_tb_top.sv
`timescale 1ns/100ps
module pfadd_join_tb_top;

  localparam int LIMIT = 150000;
  localparam logic [31:0] QN = 32'h7FC0_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] src_a_data, src_b_data, sum_data;
  logic        src_a_valid, src_b_valid, src_a_ready, src_b_ready;
  logic        sum_valid, sum_ready;

  always #2.5 clk = ~clk;

  pfadd_join dut_i (
    .clk(clk), .rst_n(rst_n),
    .src_a_data(src_a_data), .src_a_valid(src_a_valid), .src_a_ready(src_a_ready),
    .src_b_data(src_b_data), .src_b_valid(src_b_valid), .src_b_ready(src_b_ready),
    .sum_data(sum_data), .sum_valid(sum_valid), .sum_ready(sum_ready)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit wd       = 1'b0;

  logic [63:0] qa[$];
  logic [63:0] qb[$];
  logic [63:0] qexp[$];
  string       qtag[$];
  int          acc_t[$];

  int gap_pct   = 0;
  int stall_pct = 0;
  bit lat_strict = 1'b0;
  int first_acc = -1;
  int last_acc  = -1;
  bit a_hold = 1'b0, b_hold = 1'b0;
  bit prev_stall = 1'b0;
  logic [63:0] prev_data;

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // exact wide-integer model of a flush-to-zero, nearest-even single add
  function automatic logic [31:0] ref_add(input logic [31:0] a, input logic [31:0] b);
    logic signed [283:0] va, vb, s;
    logic [283:0] mag, m, rem, half;
    logic sg;
    int ea, eb, p, sh, ee;
    ea = int'(a[30:23]);
    eb = int'(b[30:23]);
    if ((ea == 255 && a[22:0] != 0) || (eb == 255 && b[22:0] != 0)) return QN;
    if (ea == 255 && eb == 255 && a[31] != b[31]) return QN;
    if (ea == 255) return a;
    if (eb == 255) return b;
    va = (ea == 0) ? '0 : $signed(284'({1'b1, a[22:0]}) << (ea - 1));
    vb = (eb == 0) ? '0 : $signed(284'({1'b1, b[22:0]}) << (eb - 1));
    if (a[31]) va = -va;
    if (b[31]) vb = -vb;
    s = va + vb;
    if (s == 0) return {a[31] & b[31], 31'b0};
    sg  = s < 0;
    mag = sg ? 284'(-s) : 284'(s);
    p = -1;
    for (int i = 0; i < 284; i++) if (mag[i]) p = i;
    if (p < 23) return {sg, 31'b0};
    sh = p - 23;
    m  = mag >> sh;
    if (sh > 0) begin
      rem  = mag & ((284'(1) << sh) - 1);
      half = 284'(1) << (sh - 1);
      if (rem > half || (rem == half && m[0])) m = m + 1;
    end
    if (m[24]) begin
      m = m >> 1;
      p++;
    end
    ee = p - 22;
    if (ee >= 255) return {sg, 8'hFF, 23'b0};
    return {sg, ee[7:0], m[22:0]};
  endfunction

  function automatic logic [31:0] rnd_fp();
    logic [7:0] e;
    if ($urandom_range(3) == 0) return $urandom;
    e = 8'($urandom_range(110, 145));
    return {1'($urandom_range(1)), e, 23'($urandom)};
  endfunction

  task automatic hdr(logic [63:0] len, logic [63:0] bval, string tag);
    qa.push_back(len);
    qb.push_back(bval);
    qexp.push_back(len);
    qtag.push_back(tag);
  endtask

  task automatic pair(logic [31:0] a0, logic [31:0] b0, logic [31:0] e0,
                      logic [31:0] a1, logic [31:0] b1, logic [31:0] e1, string tag);
    qa.push_back({a1, a0});
    qb.push_back({b1, b0});
    qexp.push_back({e1, e0});
    qtag.push_back(tag);
  endtask

  task automatic pair_ref(string tag);
    logic [31:0] a0, a1, b0, b1;
    a0 = rnd_fp(); a1 = rnd_fp(); b0 = rnd_fp(); b1 = rnd_fp();
    pair(a0, b0, ref_add(a0, b0), a1, b1, ref_add(a1, b1), tag);
  endtask

  task automatic step();
    bit fire;
    logic [63:0] ex;
    string tg;
    int t;
    @(negedge clk);
    cyc++;
    if (cyc > LIMIT) wd = 1'b1;
    if (prev_stall)
      chk(sum_valid && sum_data == prev_data, "R11 hold under stall", sum_data, prev_data);
    if (!a_hold) src_a_valid = (qa.size() > 0) && ($urandom_range(99) >= gap_pct);
    if (!b_hold) src_b_valid = (qb.size() > 0) && ($urandom_range(99) >= gap_pct);
    src_a_data = (qa.size() > 0) ? qa[0] : 64'h0;
    src_b_data = (qb.size() > 0) ? qb[0] : 64'h0;
    sum_ready  = ($urandom_range(99) >= stall_pct);
    #1;
    chk(src_a_ready == src_b_ready, "R2 readies paired", {63'b0, src_a_ready}, {63'b0, src_b_ready});
    if (src_a_ready)
      chk(src_a_valid && src_b_valid, "R2 ready needs both valid", 64'(src_a_ready), 64'(src_a_valid && src_b_valid));
    if (src_a_valid && src_b_valid && sum_ready)
      chk(src_a_ready, "R2 ready when free", 64'(src_a_ready), 64'd1);
    fire = src_a_valid && src_b_valid && src_a_ready;
    if (fire) begin
      void'(qa.pop_front());
      void'(qb.pop_front());
      acc_t.push_back(cyc);
      if (first_acc < 0) first_acc = cyc;
      last_acc = cyc;
    end
    a_hold = src_a_valid && !fire;
    b_hold = src_b_valid && !fire;
    if (sum_valid && sum_ready) begin
      if (qexp.size() == 0) begin
        chk(1'b0, "R1 unexpected output word", sum_data, 64'h0);
      end else begin
        ex = qexp.pop_front();
        tg = qtag.pop_front();
        t  = acc_t.pop_front();
        chk(sum_data == ex, tg, sum_data, ex);
        if (lat_strict)
          chk(cyc - t == 2, "R10 latency", 64'(cyc - t), 64'd2);
      end
    end
    prev_stall = sum_valid && !sum_ready;
    prev_data  = sum_data;
  endtask

  task automatic drain();
    while (!wd && (qa.size() > 0 || qexp.size() > 0)) step();
    repeat (4) step();
  endtask

  initial begin
    rst_n = 1'b0;
    src_a_valid = 1'b0; src_b_valid = 1'b0;
    src_a_data = '0; src_b_data = '0;
    sum_ready = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(!sum_valid, "R11 reset output idle", 64'(sum_valid), 64'd0);
    chk(!src_a_ready && !src_b_ready, "R2 reset no ready", 64'(src_a_ready), 64'd0);

    // stall-free: exact latency and one pair per clock (R10, R3)
    lat_strict = 1'b1; gap_pct = 0; stall_pct = 0;
    hdr(64'd8, 64'd8, "R1 header");
    for (int i = 0; i < 8; i++) pair_ref("R3 lane sum");
    first_acc = -1;
    drain();
    chk(last_acc - first_acc == 8, "R10 throughput", 64'(last_acc - first_acc), 64'd8);
    lat_strict = 1'b0;

    // directed arithmetic corners
    hdr(64'd7, 64'h0000_DEAD_0000_BEEF, "R1 header from A only");
    pair(32'h3F80_0000, 32'h4000_0000, 32'h4040_0000,
         32'h3FC0_0000, 32'hBF00_0000, 32'h3F80_0000, "R3 lanes independent");
    pair(32'h3F80_0000, 32'h3380_0000, 32'h3F80_0000,
         32'h3F80_0001, 32'h3380_0000, 32'h3F80_0002, "R4 ties to even");
    pair(32'h0000_0001, 32'h3F80_0000, 32'h3F80_0000,
         32'h8040_0000, 32'h0000_0000, 32'h0000_0000, "R5 denormal operand is zero");
    pair(32'h0080_0001, 32'h8080_0000, 32'h0000_0000,
         32'h8080_0001, 32'h0080_0000, 32'h8000_0000, "R6 tiny flushed signed");
    pair(32'h4120_0000, 32'hC120_0000, 32'h0000_0000,
         32'h8000_0000, 32'h8000_0000, 32'h8000_0000, "R6 cancel and negative zero");
    pair(32'h7F7F_FFFF, 32'h7F7F_FFFF, 32'h7F80_0000,
         32'hFF7F_FFFF, 32'hFF7F_FFFF, 32'hFF80_0000, "R7 overflow to infinity");
    pair(32'h7FC0_0001, 32'h3F80_0000, QN,
         32'h7F80_0000, 32'hFF80_0000, QN, "R8 NaN results");
    hdr(64'd1, 64'd1, "R1 header");
    pair(32'hFF80_0000, 32'h4000_0000, 32'hFF80_0000,
         32'h3F80_0000, 32'h7FA0_0000, QN, "R8 infinity and signalling NaN");

    // zero-length frames between others (R9)
    hdr(64'd0, 64'd0, "R9 empty frame header");
    hdr(64'd0, 64'd0, "R9 second empty frame");
    hdr(64'd2, 64'd2, "R9 header after empty frame");
    pair(32'h4000_0000, 32'h4000_0000, 32'h4080_0000,
         32'h4040_0000, 32'hBF80_0000, 32'h4000_0000, "R9 payload after empty frame");
    pair_ref("R9 payload after empty frame");
    drain();

    // random frames with input gaps and output backpressure (R11, R4, R3)
    gap_pct = 30; stall_pct = 40;
    for (int f = 0; f < 40; f++) begin
      int n;
      n = $urandom_range(12);
      hdr(64'(n), 64'(n), "R1 random header");
      for (int k = 0; k < n; k++) pair_ref("R4 random lane sums");
    end
    drain();

    if (wd) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, LIMIT);
    end
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule